// File: doc/BRIEF.md
# Serial Median-of-Three Unit

This block finds the median of three unsigned samples that arrive one per clock on a single data input. A one-cycle `start` pulse marks the cycle that carries the first sample, and the next two samples follow in the two cycles after it. No sorting network is used. Instead, two registers keep the largest value seen so far (the top register) and the second-largest value seen so far (the runner-up register). Each incoming sample is compared against both registers, and the registers shift or load according to the result.

A small four-state controller steps through the three load cycles. In the cycle after the third sample has been absorbed, the runner-up register holds the median. The controller shows it on `median` together with a one-cycle `done` pulse. In that same cycle both registers are cleared, so the block is ready for a new set. A `start` that arrives while a set is in progress is ignored. Reset is asynchronous and active low, and every register updates on the rising edge of the clock.

Top module: `med3_serial`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `done` is 0 and `median` is 0. A reset asserted in the middle of a set abandons that set.
- R2: If `start`=1 in cycle k with samples a, b, c on `din` in cycles k, k+1 and k+2, then in cycle k+3 `done`=1 and `median` equals the middle value of {a, b, c}.
- R3: `done` is high for exactly one cycle per set. It is low in cycles k+1 and k+2 and again in cycle k+4.
- R4: Comparisons use strict greater-than, and equal values take the not-greater path. Sets that contain duplicate values still give the true median (for example {5,5,9} gives 5 and {9,9,9} gives 9). At all times the top register is greater than or equal to the runner-up register.
- R5: The `done` cycle clears both registers. In cycle k+4, `median` reads 0.
- R6: A `start` that is high in cycles k+1 through k+3 has no effect. The running set still gives its correct median, and no further `done` follows.
- R7: A new set may start in cycle k+4, the cycle right after `done`. It gives its own correct median with no trace of the previous set.
- R8: Samples are compared as unsigned W-bit numbers. With W=8, 8'h80 counts as greater than 8'h7F.
- R9: While idle with `start` low, changes on `din` leave `done` at 0 and `median` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse marking the first sample of a set |
| din | input | W | Sample input, one sample per cycle for three cycles |
| median | output | W | Median result, valid while `done` is high |
| done | output | 1 | One-cycle pulse: result valid, registers cleared at the next edge |

## Verification
The cycle that raises `done` is also the cycle that clears both registers. A `start` can land in that same cycle, where it must be ignored, or in the very next cycle, where it must be accepted. The bench drives a `start` that is held high from the first sample through the `done` cycle, and checks that only one `done` appears and that its median belongs to the set that was in progress. It also chains sets with no gap between them and checks that each set's median, and the zero that `median` reads between sets, match values computed by hand from the three samples.

// File: rtl/med3_pkg.sv
package med3_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOAD2  = 2'd1,
    ST_LOAD3  = 2'd2,
    ST_FINISH = 2'd3
  } med3_state_e;

endpackage

// File: rtl/med3_ctrl.sv
module med3_ctrl
  import med3_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load1,
  output logic load2,
  output logic load3,
  output logic clr,
  output logic done
);

  med3_state_e state_q, state_d;

  // next-state process
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start) state_d = ST_LOAD2;
      ST_LOAD2:  state_d = ST_LOAD3;
      ST_LOAD3:  state_d = ST_FINISH;
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign load1 = (state_q == ST_IDLE) && start;
  assign load2 = (state_q == ST_LOAD2);
  assign load3 = (state_q == ST_LOAD3);
  assign done  = (state_q == ST_FINISH);
  assign clr   = done;

  // R3: done never lasts longer than one cycle
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: a new set is entered only from idle with start high
  p_busy_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) && start |=> (state_q != ST_LOAD2));

endmodule

// File: rtl/med3_datapath.sv
module med3_datapath #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         load1,
  input  logic         load2,
  input  logic         load3,
  input  logic         clr,
  output logic [W-1:0] second
);

  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] top_q, top_d;
  logic [W-1:0] sec_q, sec_d;
  logic         gt_top, gt_sec, reg_en;

  assign gt_top = (din > top_q);
  assign gt_sec = (din > sec_q);
  assign reg_en = clr | load1 | load2 | load3;

  // next-value process
  always_comb begin
    top_d = top_q;
    sec_d = sec_q;
    if (clr) begin
      top_d = ZERO;
      sec_d = ZERO;
    end else if (load1) begin
      top_d = din;
    end else if (load2) begin
      if (gt_top) begin
        sec_d = top_q;
        top_d = din;
      end else begin
        sec_d = din;
      end
    end else if (load3) begin
      if (gt_top) begin
        sec_d = top_q;
        top_d = din;
      end else if (gt_sec) begin
        sec_d = din;
      end
    end
  end

  // registers with explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q <= ZERO;
      sec_q <= ZERO;
    end else if (reg_en) begin
      top_q <= top_d;
      sec_q <= sec_d;
    end
  end

  assign second = sec_q;

  // R4: the top register never falls below the runner-up
  p_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    top_q >= sec_q);

  // R5: the done cycle leaves both registers at zero
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (top_q == ZERO) && (sec_q == ZERO));

endmodule

// File: rtl/med3_serial.sv
module med3_serial #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] din,
  output logic [W-1:0] median,
  output logic         done
);

  logic load1, load2, load3, clr;

  med3_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .load1 (load1),
    .load2 (load2),
    .load3 (load3),
    .clr   (clr),
    .done  (done)
  );

  med3_datapath #(.W(W)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (din),
    .load1  (load1),
    .load2  (load2),
    .load3  (load3),
    .clr    (clr),
    .second (median)
  );

  // R2: done arrives exactly three cycles after an accepted start
  p_done_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start, 3));

endmodule

// File: tb/med3_serial_bench.sv
module med3_serial_bench;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [W-1:0] din;
  logic [W-1:0] median;
  logic         done;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  med3_serial #(.W(W)) u_med3_serial (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .din    (din),
    .median (median),
    .done   (done)
  );

  // {a, b, c, expected median}
  localparam logic [31:0] VECS [11] = '{
    {8'd10,  8'd20,  8'd30,  8'd20},
    {8'd30,  8'd20,  8'd10,  8'd20},
    {8'd20,  8'd30,  8'd10,  8'd20},
    {8'd5,   8'd5,   8'd9,   8'd5},
    {8'd9,   8'd9,   8'd9,   8'd9},
    {8'd7,   8'd3,   8'd3,   8'd3},
    {8'h80,  8'h7F,  8'hFF,  8'h80},
    {8'd0,   8'd255, 8'd1,   8'd1},
    {8'd200, 8'd100, 8'd150, 8'd150},
    {8'd1,   8'd2,   8'd2,   8'd2},
    {8'd50,  8'd40,  8'd30,  8'd40}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Entered just after a falling edge; returns just after a falling edge
  // in the cycle following done (start low there).
  task automatic run_set(input logic [W-1:0] a, b, c, e,
                         input bit hold_start, input string req);
    start = 1'b1; din = a;
    @(negedge clk);
    chk("R3", "done low after 1st sample", {31'd0, done}, 32'd0);
    start = hold_start; din = b;
    @(negedge clk);
    chk("R3", "done low after 2nd sample", {31'd0, done}, 32'd0);
    din = c;
    @(negedge clk);
    chk(req, "done in result cycle", {31'd0, done}, 32'd1);
    chk(req, "median value", {24'd0, median}, {24'd0, e});
    din = 8'hA5;
    @(negedge clk);
    start = 1'b0;
    chk("R3", "done low after pulse", {31'd0, done}, 32'd0);
    chk("R5", "median cleared after done", {24'd0, median}, 32'd0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; din = '0;
    #1;
    chk("R1", "done in reset", {31'd0, done}, 32'd0);
    chk("R1", "median in reset", {24'd0, median}, 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "done after reset", {31'd0, done}, 32'd0);

    // R9: idle input activity without start
    for (int i = 0; i < 4; i++) begin
      din = 8'(8'h3C + 8'(i * 37));
      @(negedge clk);
      chk("R9", "idle done", {31'd0, done}, 32'd0);
      chk("R9", "idle median", {24'd0, median}, 32'd0);
    end

    // table walk, sets chained back to back (R2)
    for (int i = 0; i < 11; i++) begin
      run_set(VECS[i][31:24], VECS[i][23:16], VECS[i][15:8], VECS[i][7:0],
              1'b0, "R2");
    end

    // R4: duplicate values
    run_set(8'd5, 8'd5, 8'd9, 8'd5, 1'b0, "R4");
    run_set(8'd9, 8'd9, 8'd9, 8'd9, 1'b0, "R4");
    run_set(8'd4, 8'd8, 8'd8, 8'd8, 1'b0, "R4");

    // R8: unsigned ordering across the MSB
    run_set(8'h7F, 8'h80, 8'h01, 8'h7F, 1'b0, "R8");
    run_set(8'hFE, 8'h80, 8'hFF, 8'hFE, 1'b0, "R8");

    // R7: large values followed at once by small ones
    run_set(8'd250, 8'd240, 8'd245, 8'd245, 1'b0, "R7");
    run_set(8'd1,   8'd3,   8'd2,   8'd2,   1'b0, "R7");

    // R6: start held high through the busy and done cycles
    run_set(8'd60, 8'd90, 8'd70, 8'd70, 1'b1, "R6");
    for (int i = 0; i < 4; i++) begin
      din = 8'd99;
      @(negedge clk);
      chk("R6", "no extra done", {31'd0, done}, 32'd0);
    end

    // R1: reset in the middle of a set
    start = 1'b1; din = 8'd77;
    @(negedge clk);
    start = 1'b0; din = 8'd88;
    rst_n = 1'b0;
    #1;
    chk("R1", "median after mid-set reset", {24'd0, median}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    din = 8'd55;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R1", "no done after abandoned set", {31'd0, done}, 32'd0);
    end
    run_set(8'd11, 8'd33, 8'd22, 8'd22, 1'b0, "R1");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule